// File: doc/BRIEF.md
# Chainable One-Shot / Periodic Interval Timer

This block is a single timer channel with a 16-bit counter and an 8-bit prescaler. Software programs it through a simple write-strobe / read-address register port. The counter can run once (one-shot) or repeat (periodic), and it can count down from an interval value or up from zero towards it. The channel can hold off counting until a pulse arrives from the previous timer in a chain, and it can send a pulse to the next timer on every time-out. It can also freeze the count into a readable snapshot at each periodic time-out.

Two sticky status bits record time-outs and count/match hits. Each drives an interrupt line through its own enable. The time-out interrupt is masked out of reset. The register port carries no data stream, so it has no valid/ready pairing and no back-pressure. A write lands on the next clock edge. A read is combinational from `rd_addr`.

Register addresses on the 3-bit port: 0 mode, 1 control, 2 interval, 3 match, 4 prescale, 5 value, 6 status, 7 live count. Bit positions are given in the requirements that use them.

Top module: `tmr16_chan`

## Requirements
- R1: After reset the mode register (address 0) reads 0x0020, control (address 1) reads 0, status (address 6) reads 0, the live count (address 7) reads 0, and `irq_timeout`, `irq_match` and `trig_out` are low.
- R2: Mode bits [1:0] = 2 select periodic operation. With mode bit 2 = 0 (down), writing the interval (address 2) or the mode register reloads the count to the interval. Each tick then decrements the count. A tick taken at count 0 is a time-out, which sets the count back to the interval, so one period is interval+1 ticks.
- R3: With mode bit 2 = 1 (up), a restart sets the count to 0. Each tick increments the count. A tick taken at count == interval is a time-out, which returns the count to 0.
- R4: Mode bits [1:0] = 1 select one-shot. At the first time-out the count returns to its start value, control bit 0 clears itself, and the count then stays put.
- R5: Control bit 0 starts the timer when set and stops it when cleared. While stopped, the count holds its value.
- R6: With mode bit 3 set, an enabled timer holds its count until a `trig_in` pulse arrives. It counts from the cycle after that pulse. A `trig_in` pulse while disabled has no effect.
- R7: With mode bit 4 set in periodic mode, the count is latched into a snapshot at each time-out. Address 5 then reads the snapshot rather than the live count.
- R8: Status bit 0 is set by every time-out. `irq_timeout` is status bit 0 masked by mode bit 5, which is set at reset and blocks the interrupt while set.
- R9: Status bit 1 is set when a tick moves the count onto the match value (address 3). `irq_match` is status bit 1 gated by mode bit 6.
- R10: Status bits are sticky. Writing 1 to a bit of address 6 clears only that bit.
- R11: With mode bit 7 set, each time-out gives a one-cycle `trig_out` pulse in the cycle after the time-out tick. With bit 7 clear, `trig_out` stays low.
- R12: The count ticks once every prescale+1 enabled cycles, where prescale is bits [7:0] of address 4. Bits [15:8] of address 4 hold a prescale match value. Both read back as written.
- R13: Mode values 0 and 3 keep the counter stopped even when enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 16 | Combinational read data |
| trig_in | input | 1 | Start pulse from previous timer in chain |
| trig_out | output | 1 | Time-out pulse to next timer in chain |
| irq_timeout | output | 1 | Time-out interrupt |
| irq_match | output | 1 | Match interrupt |

## Verification
A register write appears on the read port one clock after its strobe. An enable write produces its first count change one clock after that, and a down-count then times out interval+1 ticks later. Status bits, interrupts, the snapshot and `trig_out` all change on the edge that ends the time-out tick. A chain trigger starts counting on the second edge after the pulse. With a prescale of p, the first count step comes p+1 cycles after enable. The bench queues each expected value with the exact cycle number derived from these latencies. A monitor compares the outputs at the falling edge of that cycle, well away from the edge that updates them.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_MODE  = 3'd0;
  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd1;
  localparam logic [ADDR_W-1:0] A_LOAD  = 3'd2;
  localparam logic [ADDR_W-1:0] A_MATCH = 3'd3;
  localparam logic [ADDR_W-1:0] A_PSC   = 3'd4;
  localparam logic [ADDR_W-1:0] A_VALUE = 3'd5;
  localparam logic [ADDR_W-1:0] A_STAT  = 3'd6;
  localparam logic [ADDR_W-1:0] A_COUNT = 3'd7;

  typedef enum logic [1:0] {
    M_OFF      = 2'd0,
    M_ONESHOT  = 2'd1,
    M_PERIODIC = 2'd2,
    M_CAPTURE  = 2'd3
  } run_mode_e;

  // bit 7 .. bit 0
  typedef struct packed {
    logic      trig_out_en;
    logic      match_ie;
    logic      to_int_dis;
    logic      snap_en;
    logic      wait_trig;
    logic      dir_up;
    run_mode_e mode;
  } mode_cfg_t;

  localparam int MODE_W = $bits(mode_cfg_t);

  localparam mode_cfg_t MODE_RST = '{
    trig_out_en: 1'b0, match_ie: 1'b0, to_int_dis: 1'b1, snap_en: 1'b0,
    wait_trig: 1'b0, dir_up: 1'b0, mode: M_OFF};
endpackage

// File: rtl/tmr16_prescale.sv
module tmr16_prescale #(
  parameter int PSC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [PSC_W-1:0] psc_val,
  output logic             tick
);
  logic [PSC_W-1:0] psc_cnt;

  assign tick = run && (psc_cnt >= psc_val);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      psc_cnt <= '0;
    end else if (run) begin
      psc_cnt <= tick ? '0 : psc_cnt + PSC_W'(1);
    end
  end

  // after a tick the divider starts a fresh interval
  p_psc_wrap_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !restart) |=> (psc_cnt == '0));
endmodule

// File: rtl/tmr16_counter.sv
module tmr16_counter
  import tmr16_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             restart,
  input  logic             dir_up,
  input  logic             snap_en,
  input  run_mode_e        mode,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] match_val,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] snap,
  output logic             evt_timeout,
  output logic             evt_match,
  output logic             oneshot_done
);
  logic [CNT_W-1:0] start_val;
  logic [CNT_W-1:0] cnt_next;
  logic             at_end;

  always_comb begin
    start_val   = dir_up ? '0 : load_val;
    at_end      = dir_up ? (cnt >= load_val) : (cnt == '0);
    evt_timeout = tick && at_end;
    if (evt_timeout)  cnt_next = start_val;
    else if (dir_up)  cnt_next = cnt + CNT_W'(1);
    else              cnt_next = cnt - CNT_W'(1);
    evt_match    = tick && (cnt_next == match_val);
    oneshot_done = evt_timeout && (mode == M_ONESHOT);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (restart) begin
      cnt <= start_val;
    end else if (tick) begin
      cnt <= cnt_next;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snap <= '0;
    end else if (evt_timeout && snap_en && (mode == M_PERIODIC)) begin
      snap <= cnt;
    end
  end

  p_down_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !restart && !dir_up && (cnt != '0)) |=> (cnt == $past(cnt) - CNT_W'(1)));

  p_up_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !restart && dir_up && (cnt < load_val)) |=> (cnt == $past(cnt) + CNT_W'(1)));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !restart) |=> $stable(cnt));
endmodule

// File: rtl/tmr16_regs.sv
module tmr16_regs
  import tmr16_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PSC_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_data,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [CNT_W-1:0]  snap,
  input  logic              evt_timeout,
  input  logic              evt_match,
  input  logic              oneshot_done,
  output mode_cfg_t         cfg,
  output logic              enable,
  output logic [CNT_W-1:0]  load_val,
  output logic [CNT_W-1:0]  match_val,
  output logic [PSC_W-1:0]  psc_val,
  output logic              restart,
  output logic              irq_timeout,
  output logic              irq_match
);
  logic [PSC_W-1:0] psc_match;
  logic             st_to;
  logic             st_match;
  logic             wr_mode, wr_ctrl, wr_load, wr_match, wr_psc, wr_stat;

  assign wr_mode  = wr_en && (wr_addr == A_MODE);
  assign wr_ctrl  = wr_en && (wr_addr == A_CTRL);
  assign wr_load  = wr_en && (wr_addr == A_LOAD);
  assign wr_match = wr_en && (wr_addr == A_MATCH);
  assign wr_psc   = wr_en && (wr_addr == A_PSC);
  assign wr_stat  = wr_en && (wr_addr == A_STAT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg       <= MODE_RST;
      enable    <= 1'b0;
      load_val  <= '0;
      match_val <= '0;
      psc_val   <= '0;
      psc_match <= '0;
      restart   <= 1'b0;
    end else begin
      // restart is one cycle late so the counter sees the new settings
      restart <= wr_mode || wr_load;
      if (wr_mode)  cfg       <= mode_cfg_t'(wr_data[MODE_W-1:0]);
      if (wr_load)  load_val  <= wr_data;
      if (wr_match) match_val <= wr_data;
      if (wr_psc) begin
        psc_val   <= wr_data[PSC_W-1:0];
        psc_match <= wr_data[2*PSC_W-1:PSC_W];
      end
      if (wr_ctrl)           enable <= wr_data[0];
      else if (oneshot_done) enable <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_to    <= 1'b0;
      st_match <= 1'b0;
    end else begin
      st_to    <= evt_timeout || (st_to    && !(wr_stat && wr_data[0]));
      st_match <= evt_match   || (st_match && !(wr_stat && wr_data[1]));
    end
  end

  assign irq_timeout = st_to && !cfg.to_int_dis;
  assign irq_match   = st_match && cfg.match_ie;

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_MODE:  rd_data[MODE_W-1:0]  = cfg;
      A_CTRL:  rd_data[0]           = enable;
      A_LOAD:  rd_data              = load_val;
      A_MATCH: rd_data              = match_val;
      A_PSC:   rd_data[2*PSC_W-1:0] = {psc_match, psc_val};
      A_VALUE: rd_data              = cfg.snap_en ? snap : cnt;
      A_STAT:  rd_data[1:0]         = {st_match, st_to};
      default: rd_data              = cnt;
    endcase
  end

  p_to_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_to && !(wr_stat && wr_data[0])) |=> st_to);

  p_match_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_match && !(wr_stat && wr_data[1])) |=> st_match);

  p_oneshot_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (oneshot_done && !wr_ctrl) |=> !enable);
endmodule

// File: rtl/tmr16_chan.sv
module tmr16_chan
  import tmr16_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PSC_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_data,
  input  logic              trig_in,
  output logic              trig_out,
  output logic              irq_timeout,
  output logic              irq_match
);
  mode_cfg_t        cfg;
  logic             enable, restart, run, tick, armed, mode_runs;
  logic [CNT_W-1:0] load_val, match_val, count, snap;
  logic [PSC_W-1:0] psc_val;
  logic             evt_timeout, evt_match, oneshot_done;

  tmr16_regs #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .cnt(count), .snap(snap),
    .evt_timeout(evt_timeout), .evt_match(evt_match), .oneshot_done(oneshot_done),
    .cfg(cfg), .enable(enable), .load_val(load_val), .match_val(match_val),
    .psc_val(psc_val), .restart(restart), .irq_timeout(irq_timeout),
    .irq_match(irq_match));

  // chain gate: a trigger only counts while the channel is enabled
  always_ff @(posedge clk) begin
    if (!rst_n || !enable) armed <= 1'b0;
    else if (trig_in)      armed <= 1'b1;
  end

  assign mode_runs = (cfg.mode == M_ONESHOT) || (cfg.mode == M_PERIODIC);
  assign run = enable && mode_runs && (!cfg.wait_trig || armed);

  tmr16_prescale #(.PSC_W(PSC_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .run(run), .restart(restart),
    .psc_val(psc_val), .tick(tick));

  tmr16_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .restart(restart),
    .dir_up(cfg.dir_up), .snap_en(cfg.snap_en), .mode(cfg.mode),
    .load_val(load_val), .match_val(match_val), .cnt(count), .snap(snap),
    .evt_timeout(evt_timeout), .evt_match(evt_match), .oneshot_done(oneshot_done));

  always_ff @(posedge clk) begin
    if (!rst_n) trig_out <= 1'b0;
    else        trig_out <= evt_timeout && cfg.trig_out_en;
  end

  p_wait_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.wait_trig && !armed && !restart) |=> $stable(count));

  p_trig_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
    trig_out |-> $past(evt_timeout));

  p_stopped_mode_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_runs && !restart) |=> $stable(count));
endmodule

// File: tb/tmr16_chan_test.sv
`timescale 1ns/1ps
module tmr16_chan_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        trig_in = 1'b0;
  logic        trig_out, irq_timeout, irq_match;

  int cyc = 0;
  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  localparam int K_RD = 0, K_IRQT = 1, K_IRQM = 2, K_TRIG = 3;

  typedef struct {
    int          due;
    int          kind;
    logic [2:0]  addr;
    logic [15:0] exp;
    string       tag;
  } item_t;
  item_t sb[$];

  tmr16_chan uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .trig_in(trig_in), .trig_out(trig_out),
    .irq_timeout(irq_timeout), .irq_match(irq_match));

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compare due items at the falling edge
  always @(negedge clk) begin
    int i;
    logic [15:0] obs;
    i = 0;
    while (i < sb.size()) begin
      if (sb[i].due <= cyc) begin
        case (sb[i].kind)
          K_RD: begin rd_addr = sb[i].addr; #0.1; obs = rd_data; end
          K_IRQT: obs = {15'd0, irq_timeout};
          K_IRQM: obs = {15'd0, irq_match};
          default: obs = {15'd0, trig_out};
        endcase
        n_run++;
        if (obs !== sb[i].exp || sb[i].due != cyc) begin
          n_fail++;
          $display("FAIL %s: got %h expected %h (cycle %0d due %0d)",
                   sb[i].tag, obs, sb[i].exp, cyc, sb[i].due);
        end
        sb.delete(i);
      end else begin
        i++;
      end
    end
  end

  task automatic push(int dly, int kind, logic [2:0] a, logic [15:0] e, string tag);
    item_t it;
    it.due = cyc + dly; it.kind = kind; it.addr = a; it.exp = e; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic idle(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic pulse_trig();
    trig_in = 1'b1;
    @(posedge clk); #1;
    trig_in = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got hang expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    push(0, K_RD, 3'd0, 16'h0020, "R1 mode reset");
    push(0, K_RD, 3'd1, 16'h0000, "R1 ctrl reset");
    push(0, K_RD, 3'd6, 16'h0000, "R1 status reset");
    push(0, K_RD, 3'd7, 16'h0000, "R1 count reset");
    push(0, K_IRQT, 3'd0, 16'd0, "R1 irq_timeout reset");
    push(0, K_IRQM, 3'd0, 16'd0, "R1 irq_match reset");
    push(0, K_TRIG, 3'd0, 16'd0, "R1 trig_out reset");
    idle(2);

    // R2 down periodic, trig out enabled, timeout irq allowed
    wr(3'd0, 16'h0082);
    wr(3'd2, 16'd5);
    wr(3'd1, 16'd1);
    push(0, K_RD, 3'd7, 16'd5, "R2 start value");
    push(1, K_RD, 3'd7, 16'd4, "R2 first step");
    push(5, K_RD, 3'd7, 16'd0, "R2 reaches zero");
    push(5, K_IRQT, 3'd0, 16'd0, "R8 no irq before time-out");
    push(6, K_IRQT, 3'd0, 16'd1, "R8 irq at time-out");
    push(6, K_TRIG, 3'd0, 16'd1, "R11 trig pulse");
    push(6, K_RD, 3'd7, 16'd5, "R2 reload");
    push(6, K_IRQM, 3'd0, 16'd0, "R9 match irq gated");
    push(6, K_RD, 3'd6, 16'h0003, "R9 match status set");
    push(7, K_TRIG, 3'd0, 16'd0, "R11 trig one cycle");
    push(7, K_RD, 3'd7, 16'd4, "R2 periodic continues");
    idle(7);
    // R5 stop holds count
    wr(3'd1, 16'd0);
    push(0, K_RD, 3'd7, 16'd3, "R5 held at stop");
    push(3, K_RD, 3'd7, 16'd3, "R5 still held");
    push(3, K_RD, 3'd1, 16'd0, "R5 ctrl clear");
    idle(4);
    wr(3'd6, 16'h0003);
    push(0, K_RD, 3'd6, 16'h0000, "R10 clear both");
    push(0, K_IRQT, 3'd0, 16'd0, "R10 irq dropped");
    idle(1);

    // R3/R4/R9 up one-shot with match irq
    wr(3'd0, 16'h0045);
    wr(3'd2, 16'd4);
    wr(3'd3, 16'd2);
    wr(3'd1, 16'd1);
    push(0, K_RD, 3'd7, 16'd0, "R3 up starts at 0");
    push(1, K_IRQM, 3'd0, 16'd0, "R9 no match yet");
    push(2, K_RD, 3'd7, 16'd2, "R3 count 2");
    push(2, K_IRQM, 3'd0, 16'd1, "R9 match irq");
    push(4, K_RD, 3'd7, 16'd4, "R3 count at interval");
    push(5, K_RD, 3'd7, 16'd0, "R3 returns to 0");
    push(5, K_IRQT, 3'd0, 16'd1, "R4 one-shot time-out");
    push(5, K_RD, 3'd1, 16'd0, "R4 enable self-cleared");
    push(5, K_TRIG, 3'd0, 16'd0, "R11 trig off when disabled");
    push(8, K_RD, 3'd7, 16'd0, "R4 stays stopped");
    idle(9);
    wr(3'd6, 16'h0002);
    push(0, K_IRQM, 3'd0, 16'd0, "R10 match cleared");
    push(0, K_IRQT, 3'd0, 16'd1, "R10 time-out kept");
    idle(1);
    wr(3'd6, 16'h0003);

    // R7/R8 up periodic, snapshot, time-out irq masked
    wr(3'd0, 16'h0036);
    wr(3'd1, 16'd1);
    push(4, K_RD, 3'd5, 16'd0, "R7 snapshot before time-out");
    push(5, K_RD, 3'd5, 16'd4, "R7 snapshot latched");
    push(5, K_RD, 3'd6, 16'h0003, "R8 status set");
    push(5, K_IRQT, 3'd0, 16'd0, "R8 irq masked");
    push(7, K_RD, 3'd5, 16'd4, "R7 snapshot held");
    push(7, K_RD, 3'd7, 16'd2, "R7 live count moves");
    idle(8);
    wr(3'd1, 16'd0);
    wr(3'd6, 16'h0003);

    // R6 wait on trigger
    wr(3'd0, 16'h008A);
    wr(3'd2, 16'd3);
    idle(1);
    pulse_trig();
    wr(3'd1, 16'd1);
    push(0, K_RD, 3'd7, 16'd3, "R6 waiting");
    push(3, K_RD, 3'd7, 16'd3, "R6 trig while off ignored");
    idle(3);
    pulse_trig();
    push(0, K_RD, 3'd7, 16'd3, "R6 not yet counting");
    push(1, K_RD, 3'd7, 16'd2, "R6 starts after trig");
    push(4, K_TRIG, 3'd0, 16'd1, "R11 trig at time-out");
    push(4, K_IRQT, 3'd0, 16'd1, "R6 time-out after trig");
    idle(6);
    wr(3'd1, 16'd0);
    wr(3'd6, 16'h0003);

    // R12 prescaler
    wr(3'd0, 16'h0002);
    wr(3'd4, 16'h0502);
    wr(3'd2, 16'd3);
    wr(3'd1, 16'd1);
    push(0, K_RD, 3'd4, 16'h0502, "R12 prescale readback");
    push(2, K_RD, 3'd7, 16'd3, "R12 held during prescale");
    push(3, K_RD, 3'd7, 16'd2, "R12 first tick");
    push(9, K_RD, 3'd7, 16'd0, "R12 zero");
    push(11, K_IRQT, 3'd0, 16'd0, "R12 no early time-out");
    push(12, K_IRQT, 3'd0, 16'd1, "R12 time-out");
    idle(13);
    wr(3'd1, 16'd0);
    wr(3'd6, 16'h0003);
    wr(3'd4, 16'h0000);

    // R13 capture mode value stays stopped
    wr(3'd0, 16'h0003);
    wr(3'd1, 16'd1);
    push(0, K_RD, 3'd7, 16'd3, "R13 stopped");
    push(4, K_RD, 3'd7, 16'd3, "R13 still stopped");
    push(4, K_IRQT, 3'd0, 16'd0, "R13 no time-out");
    idle(6);

    done = 1'b1;
    if (sb.size() != 0) begin
      n_fail++;
      $display("FAIL scoreboard: got %0d pending expected 0", sb.size());
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule